// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block watches the output of a demodulated infrared receiver and turns the waveform into a stream of run lengths. It passes the input through a two-flop synchronizer. It then measures every high stretch (a pulse) and every low stretch (a space) in whole ticks of a programmable sample period, and packs each result into one byte. The top bit of the byte says whether the run was a space. The lower seven bits hold the tick count. A count of 0x7F is reserved as a saturation code for runs that are still in progress.

The bytes are written into an eight-byte memory that works as two four-byte halves in ping-pong fashion. When a half is complete, the block switches to the other half and raises an interrupt. A status bit then tells software which half to read. Software reaches every register through a four-port indexed window. Two ports latch a 16-bit register address, a data port reads or writes the addressed register, and a fourth port returns the status byte directly. Saturation codes can be switched off, which gives an idle mode in which a silent input never raises interrupts.

Top module: `ir_runlen_sampler`

## Requirements
- R1: Host port 1 latches the high address byte and port 2 latches the low address byte. Both read back as written. Port 3 reads or writes the register at that 16-bit address. Port 0 returns the status byte, and writes to port 0 are ignored. The register map is: control at 0x0050, status at 0x0051, period at 0x0052, and sample memory at 0x0040 to 0x0047, with half 0 at 0x0040 and half 1 at 0x0044. An unmapped address reads 0x00.
- R2: After reset, the control register reads 0x00, the status byte reads 0x01, the period register reads 0x4B, every sample byte reads 0x00, and irq is low.
- R3: A run of N clock cycles between two input edges, with k·T < N ≤ (k+1)·T, is stored as duration k, or as 1 when k is 0. Here T = period × CYC_PER_US. Bit 7 of the stored byte is 1 for a low run (space) and 0 for a high run (pulse).
- R4: When period register bit 7 is 1, a run that reaches its 127th tick stores a byte with duration 0x7F at once. Counting then restarts from zero with the same polarity, so a run of 130 ticks stores 0x7F followed by 3.
- R5: When period register bit 7 is 0, no byte with duration 0x7F is ever stored. A run longer than 127 ticks stores only its tick count modulo 127 (minimum 1).
- R6: Bytes fill slots 0 to 3 of the current half in arrival order. In the cycle the fourth byte is stored, status bit 0 changes to the index of the half just filled and status bit 5 is set. Writing then continues in the other half. Half 0 fills first.
- R7: When writing moves into a half, all four bytes of that half are cleared to 0x00. A zero duration therefore marks the end of valid data.
- R8: irq equals status bit 5 AND control bit 7. A write to the status register with bit 5 equal to 0 clears the pending bit. A write with bit 5 equal to 1 leaves it unchanged.
- R9: While control bit 0 is 0, no sample byte is stored, no half completes and the run counter is held at zero.
- R10: The period register stores bits 6..0 as the period in microseconds and bit 7 as the saturation-code enable. A written period below 5 is stored as 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated infrared receiver output, asynchronous |
| hp_addr | input | 2 | Host port select: 0 status, 1 address high, 2 address low, 3 data |
| hp_wr | input | 1 | Host write strobe for the selected port |
| hp_wdata | input | 8 | Host write data |
| hp_rdata | output | 8 | Host read data for the selected port (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A corrupted run counter or tick divider shows up as a wrong duration byte at the data port. The error appears on the first run that ends after the fault, so a scoreboard of predicted bytes catches it one half-buffer later. A wrong slot index or half pointer shows up as misplaced or shifted bytes, or as a status bit 0 that fails to alternate. Both are visible on the first interrupt. A pending bit that is set or cleared at the wrong time shows on irq within one cycle of a half completing or of a status write.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

    localparam int DUR_W = 7;
    localparam logic [DUR_W-1:0] DUR_OVF  = '1;
    localparam logic [DUR_W-1:0] DUR_LAST = DUR_OVF - 7'd1;

    localparam logic [6:0] PERIOD_MIN = 7'd5;
    localparam logic [6:0] PERIOD_RST = 7'd75;

    localparam logic [15:0] A_SAMPLE = 16'h0040;
    localparam logic [15:0] A_CTRL   = 16'h0050;
    localparam logic [15:0] A_STAT   = 16'h0051;
    localparam logic [15:0] A_PERIOD = 16'h0052;

    localparam int B_EN    = 0;
    localparam int B_IRQEN = 7;
    localparam int B_HALF  = 0;
    localparam int B_PEND  = 5;

    typedef struct packed {
        logic             space;
        logic [DUR_W-1:0] dur;
    } ir_sample_t;

    typedef enum logic [1:0] {
        P_STAT = 2'd0,
        P_AHI  = 2'd1,
        P_ALO  = 2'd2,
        P_DATA = 2'd3
    } port_e;

    function automatic logic [6:0] clamp_period(input logic [6:0] v);
        return (v < PERIOD_MIN) ? PERIOD_MIN : v;
    endfunction

endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl_prev,
    output logic edge_det
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl_prev = prev_q;
    assign edge_det = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/ir_rl_measure.sv
module ir_rl_measure
    import ir_rl_pkg::*;
#(
    parameter int CYC_PER_US = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [6:0] period,
    input  logic       ovf_store,
    input  logic       lvl_prev,
    input  logic       edge_det,
    output logic       st_valid,
    output ir_sample_t st_data
);
    localparam int DIV_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(CYC_PER_US - 1);

    logic [DIV_W-1:0] div_q;
    logic [6:0]       us_q;
    logic [DUR_W-1:0] run_q;
    logic             div_last, us_last, tick, ovf_hit;

    assign div_last = (div_q == DIV_END);
    assign us_last  = (us_q >= period - 7'd1);
    assign tick     = div_last && us_last;
    assign ovf_hit  = tick && (run_q == DUR_LAST) && ovf_store;

    always_ff @(posedge clk) begin
        if (rst || !en || edge_det) begin
            div_q <= '0;
            us_q  <= '0;
            run_q <= '0;
        end else begin
            if (div_last) begin
                div_q <= '0;
                us_q  <= us_last ? 7'd0 : us_q + 7'd1;
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
            if (tick)
                run_q <= (run_q == DUR_LAST) ? '0 : run_q + DUR_W'(1);
        end
    end

    always_comb begin
        st_valid      = en && (edge_det || ovf_hit);
        st_data.space = ~lvl_prev;
        if (edge_det)
            st_data.dur = (run_q == '0) ? DUR_W'(1) : run_q;
        else
            st_data.dur = DUR_OVF;
    end
endmodule

// File: rtl/ir_rl_pingpong.sv
module ir_rl_pingpong
    import ir_rl_pkg::*;
#(
    parameter int HALF_DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  ir_sample_t                        wr_data,
    input  logic [$clog2(2*HALF_DEPTH)-1:0]   rd_addr,
    output logic [7:0]                        rd_data,
    output logic                              half_done,
    output logic                              rd_half
);
    localparam int DEPTH = 2 * HALF_DEPTH;
    localparam int IDX_W = $clog2(HALF_DEPTH);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(HALF_DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic             wr_half;
    logic [IDX_W-1:0] wr_idx;

    assign half_done = wr_en && (wr_idx == IDX_END);
    assign rd_half   = ~wr_half;
    assign rd_data   = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_half <= 1'b0;
            wr_idx  <= '0;
        end else if (wr_en) begin
            mem[{wr_half, wr_idx}] <= wr_data;
            if (wr_idx == IDX_END) begin
                wr_idx  <= '0;
                wr_half <= ~wr_half;
                for (int i = 0; i < HALF_DEPTH; i++)
                    mem[{~wr_half, IDX_W'(i)}] <= '0;
            end else begin
                wr_idx <= wr_idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int CYC_PER_US  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HALF_DEPTH  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ir_in,
    input  logic [1:0] hp_addr,
    input  logic       hp_wr,
    input  logic [7:0] hp_wdata,
    output logic [7:0] hp_rdata,
    output logic       irq
);
    localparam int DEPTH  = 2 * HALF_DEPTH;
    localparam int BUF_AW = $clog2(DEPTH);

    logic       lvl_prev, edge_det, st_valid, half_done, rd_half;
    ir_sample_t st_data;
    logic [7:0] buf_rdata;
    logic [7:0] ahi_q, alo_q, ctrl_q;
    logic       pend_q, ovf_irq_q, run_en, data_wr;
    logic [6:0] period_q;
    logic [15:0] reg_addr, buf_off;
    logic       in_buf;
    logic [7:0] stat_byte, reg_rdata;

    ir_rl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(ir_in),
        .lvl_prev(lvl_prev), .edge_det(edge_det)
    );

    ir_rl_measure #(.CYC_PER_US(CYC_PER_US)) u_meas (
        .clk(clk), .rst(rst), .en(run_en), .period(period_q),
        .ovf_store(ovf_irq_q), .lvl_prev(lvl_prev), .edge_det(edge_det),
        .st_valid(st_valid), .st_data(st_data)
    );

    ir_rl_pingpong #(.HALF_DEPTH(HALF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .wr_en(st_valid), .wr_data(st_data),
        .rd_addr(buf_off[BUF_AW-1:0]), .rd_data(buf_rdata),
        .half_done(half_done), .rd_half(rd_half)
    );

    assign reg_addr = {ahi_q, alo_q};
    assign buf_off  = reg_addr - A_SAMPLE;
    assign in_buf   = (buf_off < 16'(DEPTH));
    assign data_wr  = hp_wr && (port_e'(hp_addr) == P_DATA);
    assign run_en   = ctrl_q[B_EN];
    assign irq      = pend_q & ctrl_q[B_IRQEN];

    always_comb begin
        stat_byte         = '0;
        stat_byte[B_HALF] = rd_half;
        stat_byte[B_PEND] = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ahi_q     <= '0;
            alo_q     <= '0;
            ctrl_q    <= '0;
            pend_q    <= 1'b0;
            period_q  <= PERIOD_RST;
            ovf_irq_q <= 1'b0;
        end else begin
            if (hp_wr && port_e'(hp_addr) == P_AHI) ahi_q <= hp_wdata;
            if (hp_wr && port_e'(hp_addr) == P_ALO) alo_q <= hp_wdata;
            if (data_wr && reg_addr == A_CTRL) ctrl_q <= hp_wdata;
            if (data_wr && reg_addr == A_PERIOD) begin
                period_q  <= clamp_period(hp_wdata[6:0]);
                ovf_irq_q <= hp_wdata[7];
            end
            if (half_done)
                pend_q <= 1'b1;
            else if (data_wr && reg_addr == A_STAT && !hp_wdata[B_PEND])
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_buf) begin
            reg_rdata = buf_rdata;
        end else begin
            case (reg_addr)
                A_CTRL:   reg_rdata = ctrl_q;
                A_STAT:   reg_rdata = stat_byte;
                A_PERIOD: reg_rdata = {ovf_irq_q, period_q};
                default:  reg_rdata = '0;
            endcase
        end
    end

    always_comb begin
        case (port_e'(hp_addr))
            P_STAT:  hp_rdata = stat_byte;
            P_AHI:   hp_rdata = ahi_q;
            P_ALO:   hp_rdata = alo_q;
            default: hp_rdata = reg_rdata;
        endcase
    end
endmodule

// File: rtl/ir_rl_checker.sv
module ir_rl_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       ovf_store,
    input logic       edge_det,
    input logic       st_valid,
    input logic [7:0] st_byte,
    input logic       half_done,
    input logic       rd_half,
    input logic       pend,
    input logic [6:0] period
);
    // R3
    nonzero_dur_chk: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_byte[6:0] != 7'd0));

    // R9
    halted_store_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !st_valid);

    // R5
    no_sat_code_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !ovf_store) |-> (st_byte[6:0] != 7'h7F));

    // R4
    sat_mid_run_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_byte[6:0] == 7'h7F) |-> !edge_det);

    // R6
    half_flip_chk: assert property (@(posedge clk) disable iff (rst)
        half_done |=> (rd_half != $past(rd_half)) && pend);

    // R10
    period_floor_chk: assert property (@(posedge clk) disable iff (rst)
        period >= 7'd5);
endmodule

bind ir_runlen_sampler ir_rl_checker u_chk (
    .clk(clk), .rst(rst), .en(run_en), .ovf_store(ovf_irq_q),
    .edge_det(edge_det), .st_valid(st_valid), .st_byte(st_data),
    .half_done(half_done), .rd_half(rd_half), .pend(pend_q),
    .period(period_q)
);

// File: tb/sim_ir_runlen_sampler.sv
module sim_ir_runlen_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_US     = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_in = 1'b1;
    logic [1:0] hp_addr = 2'd0;
    logic       hp_wr = 1'b0;
    logic [7:0] hp_wdata = 8'h00;
    logic [7:0] hp_rdata;
    logic       irq;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] sb_q[$];
    bit          mon_on = 1'b0;
    bit          mon_busy = 1'b0;
    int          exp_half = 0;
    int          tick_cyc = 10;
    bit          ovf_mode = 1'b1;

    ir_runlen_sampler #(.CYC_PER_US(CYC_US)) u0 (
        .clk(clk), .rst(rst), .ir_in(ir_in), .hp_addr(hp_addr),
        .hp_wr(hp_wr), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp,
                         logic [7:0] mask = 8'hFF);
        n_cmp++;
        if ((act & mask) !== (exp & mask)) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h (mask %02h)",
                     tag, act, exp, mask);
        end
    endtask

    task automatic port_wr(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        hp_addr = p; hp_wdata = d; hp_wr = 1'b1;
        @(negedge clk);
        hp_wr = 1'b0;
    endtask

    task automatic port_rd(input logic [1:0] p, output logic [7:0] d);
        @(negedge clk);
        hp_addr = p; hp_wr = 1'b0;
        #1 d = hp_rdata;
    endtask

    task automatic reg_wr(input logic [15:0] a, input logic [7:0] d);
        port_wr(2'd1, a[15:8]);
        port_wr(2'd2, a[7:0]);
        port_wr(2'd3, d);
    endtask

    task automatic reg_rd(input logic [15:0] a, output logic [7:0] d);
        port_wr(2'd1, a[15:8]);
        port_wr(2'd2, a[7:0]);
        port_rd(2'd3, d);
    endtask

    // scoreboard driver: push predicted bytes, then hold the level n cycles
    task automatic drive_run(input bit lvl, input int n);
        int   ticks;
        logic sp;
        ir_in = lvl;
        sp    = ~lvl;
        ticks = (n - 1) / tick_cyc;
        if (ovf_mode) begin
            while (ticks >= 127) begin
                sb_q.push_back({8'hFF, sp, 7'h7F});
                ticks -= 127;
            end
        end else begin
            ticks = ticks % 127;
        end
        sb_q.push_back({8'hFF, sp, (ticks == 0) ? 7'd1 : 7'(ticks)});
        repeat (n) @(negedge clk);
    endtask

    // first run after enabling: only its polarity is predictable
    task automatic push_first(input bit lvl);
        sb_q.push_back({8'h80, ~lvl, 7'd0});
    endtask

    // scoreboard monitor
    initial begin
        logic [7:0]  st, b;
        logic [15:0] item;
        forever begin
            wait (mon_on && irq === 1'b1);
            mon_busy = 1'b1;
            port_rd(2'd0, st);
            check("R6 status on half fill", st, {2'b00, 1'b1, 4'b0000, 1'(exp_half)});
            for (int i = 0; i < 4; i++) begin
                reg_rd(16'h0040 + 16'(st[0] * 4 + i), b);
                if (sb_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R6 unexpected byte: actual %02h expected none", b);
                end else begin
                    item = sb_q.pop_front();
                    check("R3/R4/R5 sample byte", b, item[7:0], item[15:8]);
                end
            end
            reg_wr(16'h0051, 8'h00);
            @(negedge clk);
            check("R8 irq after clear", {7'd0, irq}, 8'h00);
            exp_half = 1 - exp_half;
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset values
        check("R2 irq at reset", {7'd0, irq}, 8'h00);
        port_rd(2'd0, d);          check("R2 status port", d, 8'h01);
        reg_rd(16'h0050, d);       check("R2 control", d, 8'h00);
        reg_rd(16'h0052, d);       check("R2 period", d, 8'h4B);
        reg_rd(16'h0040, d);       check("R2 sample slot 0", d, 8'h00);
        reg_rd(16'h0047, d);       check("R2 sample slot 7", d, 8'h00);

        // R1 host window
        port_wr(2'd1, 8'h12);
        port_wr(2'd2, 8'h34);
        port_rd(2'd1, d);          check("R1 address high readback", d, 8'h12);
        port_rd(2'd2, d);          check("R1 address low readback", d, 8'h34);
        port_rd(2'd3, d);          check("R1 unmapped reads zero", d, 8'h00);
        port_wr(2'd0, 8'hFF);
        port_rd(2'd0, d);          check("R1 status port ignores writes", d, 8'h01);
        reg_wr(16'h0050, 8'h80);
        reg_rd(16'h0050, d);       check("R1 control write", d, 8'h80);

        // R10 period clamp
        reg_wr(16'h0052, 8'h02);
        reg_rd(16'h0052, d);       check("R10 period clamped", d, 8'h05);
        reg_wr(16'h0052, 8'h85);
        reg_rd(16'h0052, d);       check("R10 period with enable bit", d, 8'h85);
        tick_cyc = 5 * CYC_US;
        ovf_mode = 1'b1;

        // R9 halted: edges store nothing
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            ir_in = ~ir_in;
            repeat (40) @(negedge clk);
        end
        ir_in = 1'b1;
        repeat (10) @(negedge clk);
        port_rd(2'd0, d);          check("R9 no half completes", d, 8'h01);
        reg_rd(16'h0040, d);       check("R9 no byte stored", d, 8'h00);

        // segment 1: saturation codes enabled, irq enabled
        mon_on = 1'b1;
        reg_wr(16'h0050, 8'h81);
        push_first(1'b1);
        @(negedge clk);
        drive_run(1'b0, 25);      // R3 space of 2 ticks
        drive_run(1'b1, 10);      // R3 shorter than one tick -> 1
        drive_run(1'b0, 11);
        drive_run(1'b1, 1305);    // R4 130 ticks -> 7F then 3
        drive_run(1'b0, 1275);    // R4 exactly 127 ticks -> FF then 81
        drive_run(1'b1, 45);
        drive_run(1'b0, 70);
        drive_run(1'b1, 20);
        drive_run(1'b0, 100);
        ir_in = 1'b1;
        while (sb_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (4) @(negedge clk);
        mon_on = 1'b0;

        // R7 freshly entered half is cleared
        reg_rd(16'h0044, d);       check("R7 new half slot 0 zero", d, 8'h00);
        reg_rd(16'h0047, d);       check("R7 new half slot 3 zero", d, 8'h00);
        port_rd(2'd0, d);          check("R6 status after three fills", d, 8'h00);

        // segment 2: saturation codes disabled, irq output masked
        reg_wr(16'h0050, 8'h00);
        reg_wr(16'h0052, 8'h05);
        ovf_mode = 1'b0;
        reg_wr(16'h0050, 8'h01);
        push_first(1'b1);
        @(negedge clk);
        drive_run(1'b0, 35);
        drive_run(1'b1, 1305);    // R5 130 ticks -> 3, no 7F
        drive_run(1'b0, 1295);    // R5 129 ticks -> 82
        ir_in = 1'b1;
        repeat (10) @(negedge clk);
        check("R8 irq masked by control bit 7", {7'd0, irq}, 8'h00);
        port_rd(2'd0, d);          check("R8 pending with half 1", d, 8'h21);
        reg_wr(16'h0051, 8'h20);
        port_rd(2'd0, d);          check("R8 write of one keeps pending", d, 8'h21);
        mon_on = 1'b1;
        reg_wr(16'h0050, 8'h81);
        while (sb_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule